// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag state of a cache and tells, for each word address presented to it, whether that word is already held (a hit) or not (a miss). It stores no data. The sizing comes from three parameters: total capacity in words, ways per set and words per block. The number of sets is the capacity divided by the product of the other two. One way per set gives a direct-mapped cache. A single set gives a fully associative one. Addresses count words, so there are no byte-select bits.

Each word address splits into three fields. The block offset is in the lowest bits, the set index is in the bits just above it, and the tag takes whatever bits remain at the top. A miss installs the whole aligned block that contains the word. It goes into the lowest-numbered empty way of the set. When the set has no empty way, a victim is chosen under the policy sampled with the request: least recently used (select low) or most recently used (select high).

A small state machine has two states. `ST_IDLE` means no result is pending. `ST_RESP` means a result is being presented. Transitions: `ST_IDLE -> ST_RESP` or `ST_RESP -> ST_RESP` on an accepted request, and `ST_RESP -> ST_IDLE` or `ST_IDLE -> ST_IDLE` when no request arrives. A debug port reads back the valid bit and the block base address of any way, without a clock.

Top module: `set_assoc_tag_ctrl`

## Requirements
- R1: The result carries the decoded fields of the request address: offset = addr mod words-per-block, index = (addr / words-per-block) mod sets, tag = addr / (words-per-block × sets).
- R2: A request with `req_valid` high is accepted on a rising edge, and its result appears after that same edge with `rsp_valid` high; with no request, `rsp_valid` is low after the next edge.
- R3: A miss installs the aligned block of the word, so a later access to the other word of that block hits.
- R4: While the set has an empty way, a miss fills the lowest-numbered empty way; `rsp_way` gives the filled way on a miss and the matching way on a hit.
- R5: With the set full and `req_mru` low, a miss replaces the way that was least recently touched.
- R6: With the set full and `req_mru` high, a miss replaces the way that was most recently touched.
- R7: A hit marks its way as most recently touched.
- R8: A 24-word, 3-way, 2-words-per-block cache fed the addresses 3,180,43,2,191,88,190,14,181,44,186,253 under LRU answers miss,miss,miss,hit,miss,miss,hit,miss,hit,miss,miss,miss.
- R9: After that trace, set 0 holds base {88}, set 1 {2,42,186}, set 2 {180,44,252} and set 3 {190,14}; all other ways are empty.
- R10: Reset empties every way (debug valid low everywhere) and clears `rsp_valid`. The debug base is tag×(words-per-block×sets) + set×words-per-block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Word address of the request |
| req_mru | input | 1 | Victim policy: 0 least recently used, 1 most recently used |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_tag | output | TAG_W | Decoded tag |
| rsp_index | output | IDX_W | Decoded set index |
| rsp_offset | output | OFF_W | Decoded block offset |
| rsp_way | output | WAY_W | Way that hit or was filled |
| dbg_set | input | IDX_W | Debug set select |
| dbg_way | input | WAY_W | Debug way select |
| dbg_valid | output | 1 | Valid bit of the selected way |
| dbg_base | output | ADDR_W | Block base word address of the selected way |

## Verification
The assertions assume that the parameters divide evenly into power-of-two sizes. They also assume that a set never holds the same tag twice, and the controller keeps that true by filling a way only on a miss. They further assume that `req_mru` and `req_addr` are settled before the edge that samples `req_valid`. The bench drives every input on the falling edge and reads results on the following falling edge. It keeps addresses inside the 8-bit default width. It uses debug reads only between requests, never as a way to alter the state.

// File: rtl/tagc_pkg.sv
package tagc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/tagc_addr_split.sv
module tagc_addr_split #(
    parameter int ADDR_W   = 8,
    parameter int OFF_BITS = 1,
    parameter int IDX_BITS = 2,
    parameter int OFF_W    = 1,
    parameter int IDX_W    = 2,
    parameter int TAG_W    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_BITS) - 1);
    localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'((1 << IDX_BITS) - 1);

    logic [ADDR_W-1:0] off_full, idx_full, tag_full;

    assign off_full = addr & OFF_MASK;
    assign idx_full = (addr >> OFF_BITS) & IDX_MASK;
    assign tag_full = addr >> (OFF_BITS + IDX_BITS);
    assign off = OFF_W'(off_full);
    assign idx = IDX_W'(idx_full);
    assign tag = TAG_W'(tag_full);
endmodule

// File: rtl/tagc_victim.sv
module tagc_victim #(
    parameter int WAYS  = 3,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*WAY_W-1:0] ages,
    input  logic                  pol_mru,
    output logic [WAY_W-1:0]      victim,
    output logic                  all_full
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    always_comb begin
        victim   = '0;
        all_full = &valid;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) victim = WAY_W'(w);
        end
        if (all_full) begin
            for (int w = 0; w < WAYS; w++) begin
                if (pol_mru ? (ages[w*WAY_W +: WAY_W] == '0)
                            : (ages[w*WAY_W +: WAY_W] == OLDEST))
                    victim = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/set_assoc_tag_ctrl.sv
module set_assoc_tag_ctrl
    import tagc_pkg::*;
#(
    parameter int CACHE_WORDS = 24,
    parameter int WAYS        = 3,
    parameter int BLOCK_WORDS = 2,
    parameter int ADDR_W      = 8,
    localparam int SETS       = CACHE_WORDS / (WAYS * BLOCK_WORDS),
    localparam int OFF_BITS   = $clog2(BLOCK_WORDS),
    localparam int IDX_BITS   = $clog2(SETS),
    localparam int OFF_W      = (OFF_BITS > 0) ? OFF_BITS : 1,
    localparam int IDX_W      = (IDX_BITS > 0) ? IDX_BITS : 1,
    localparam int TAG_W      = ADDR_W - OFF_BITS - IDX_BITS,
    localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_mru,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [IDX_W-1:0]  rsp_index,
    output logic [OFF_W-1:0]  rsp_offset,
    output logic [WAY_W-1:0]  rsp_way,
    input  logic [IDX_W-1:0]  dbg_set,
    input  logic [WAY_W-1:0]  dbg_way,
    output logic              dbg_valid,
    output logic [ADDR_W-1:0] dbg_base
);
    rsp_state_e state_q, state_d;

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic             vld_q [SETS][WAYS];
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    logic [TAG_W-1:0]       req_tag;
    logic [IDX_W-1:0]       req_idx;
    logic [OFF_W-1:0]       req_off;
    logic [WAYS-1:0]        hit_vec, set_vld;
    logic [WAYS*WAY_W-1:0]  set_ages;
    logic                   any_hit, set_full;
    logic [WAY_W-1:0]       hit_way, vict_way, touch_way;

    tagc_addr_split #(
        .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .IDX_BITS(IDX_BITS),
        .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) i_split (
        .addr(req_addr), .tag(req_tag), .idx(req_idx), .off(req_off)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign set_vld[w] = vld_q[req_idx][w];
        assign hit_vec[w] = vld_q[req_idx][w] && (tag_q[req_idx][w] == req_tag);
        assign set_ages[w*WAY_W +: WAY_W] = age_q[req_idx][w];
    end

    tagc_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) i_victim (
        .valid(set_vld), .ages(set_ages), .pol_mru(req_mru),
        .victim(vict_way), .all_full(set_full)
    );

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign any_hit   = |hit_vec;
    assign touch_way = any_hit ? hit_way : vict_way;

    // State register
    always_comb state_d = req_valid ? ST_RESP : ST_IDLE;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit    <= 1'b0;
            rsp_tag    <= '0;
            rsp_index  <= '0;
            rsp_offset <= '0;
            rsp_way    <= '0;
        end else begin
            unique case (state_d)
                ST_RESP: begin
                    rsp_hit    <= any_hit;
                    rsp_tag    <= req_tag;
                    rsp_index  <= req_idx;
                    rsp_offset <= req_off;
                    rsp_way    <= touch_way;
                end
                ST_IDLE: rsp_hit <= 1'b0;
                default: rsp_hit <= 1'b0;
            endcase
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    // Tag, valid and recency arrays
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    vld_q[s][w] <= 1'b0;
                    age_q[s][w] <= '0;
                end
            end
        end else if (req_valid) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) != touch_way && vld_q[req_idx][w] &&
                    (!vld_q[req_idx][touch_way] ||
                     age_q[req_idx][w] < age_q[req_idx][touch_way]))
                    age_q[req_idx][w] <= age_q[req_idx][w] + 1'b1;
            end
            age_q[req_idx][touch_way] <= '0;
            vld_q[req_idx][touch_way] <= 1'b1;
            tag_q[req_idx][touch_way] <= req_tag;
        end
    end

    // Debug read-back
    assign dbg_valid = vld_q[dbg_set][dbg_way];
    assign dbg_base  = (ADDR_W'(tag_q[dbg_set][dbg_way]) << (OFF_BITS + IDX_BITS))
                     | (ADDR_W'(dbg_set) << OFF_BITS);

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R4
    way_range_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_way < WAY_W'(WAYS)));
    // R7
    hit_unique_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $onehot0(hit_vec));
    // R5
    lru_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !any_hit && set_full && !req_mru)
        |-> (age_q[req_idx][vict_way] == WAY_W'(WAYS - 1)));
    // R6
    mru_newest_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !any_hit && set_full && req_mru)
        |-> (age_q[req_idx][vict_way] == '0));
endmodule

// File: tb/test_set_assoc_tag_ctrl.sv
module test_set_assoc_tag_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NTR = 12;

    // {addr, expected hit, expected way}
    localparam logic [15:0] TRACE [NTR] = '{
        {8'd3,   1'b0, 7'd0}, {8'd180, 1'b0, 7'd0}, {8'd43,  1'b0, 7'd1},
        {8'd2,   1'b1, 7'd0}, {8'd191, 1'b0, 7'd0}, {8'd88,  1'b0, 7'd0},
        {8'd190, 1'b1, 7'd0}, {8'd14,  1'b0, 7'd1}, {8'd181, 1'b1, 7'd0},
        {8'd44,  1'b0, 7'd1}, {8'd186, 1'b0, 7'd2}, {8'd253, 1'b0, 7'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [7:0] req_addr = '0;
    logic       req_mru = 1'b0;
    logic       rsp_valid, rsp_hit, dbg_valid;
    logic [4:0] rsp_tag;
    logic [1:0] rsp_index, rsp_way, dbg_set = '0, dbg_way = '0;
    logic [0:0] rsp_offset;
    logic [7:0] dbg_base;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    set_assoc_tag_ctrl i_set_assoc_tag_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_mru(req_mru), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_tag(rsp_tag), .rsp_index(rsp_index), .rsp_offset(rsp_offset),
        .rsp_way(rsp_way), .dbg_set(dbg_set), .dbg_way(dbg_way),
        .dbg_valid(dbg_valid), .dbg_base(dbg_base)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic access(input int addr, input bit mru, input int exp_hit,
                          input int exp_way, input string tagname);
        req_addr = 8'(addr); req_mru = mru; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check({tagname, " rsp_valid (R2)"}, int'(rsp_valid), 1);
        check({tagname, " hit"}, int'(rsp_hit), exp_hit);
        check({tagname, " way (R4)"}, int'(rsp_way), exp_way);
        check("R1 tag", int'(rsp_tag), addr / 8);
        check("R1 index", int'(rsp_index), (addr / 2) % 4);
        check("R1 offset", int'(rsp_offset), addr % 2);
    endtask

    task automatic set_holds(input int s, input int base);
        int found = 0;
        for (int w = 0; w < 3; w++) begin
            dbg_set = 2'(s); dbg_way = 2'(w); #1;
            if (dbg_valid && dbg_base == 8'(base)) found++;
        end
        check($sformatf("R9 set %0d base %0d", s, base), found, 1);
    endtask

    task automatic set_count(input int s, input int exp);
        int n = 0;
        for (int w = 0; w < 3; w++) begin
            dbg_set = 2'(s); dbg_way = 2'(w); #1;
            if (dbg_valid) n++;
        end
        check($sformatf("R9 set %0d occupancy", s), n, exp);
    endtask

    initial begin
        do_reset();
        // R10 reset state
        check("R10 rsp_valid after reset", int'(rsp_valid), 0);
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 3; w++) begin
                dbg_set = 2'(s); dbg_way = 2'(w); #1;
                check("R10 way empty after reset", int'(dbg_valid), 0);
            end

        // R8 reference trace, LRU
        for (int i = 0; i < NTR; i++)
            access(int'(TRACE[i][15:8]), 1'b0, int'(TRACE[i][7]),
                   int'(TRACE[i][6:0]), "R8");
        @(negedge clk);
        check("R2 idle drops rsp_valid", int'(rsp_valid), 0);

        // R9 final contents, R10 base formula
        set_count(0, 1); set_holds(0, 88);
        set_count(1, 3); set_holds(1, 2); set_holds(1, 42); set_holds(1, 186);
        set_count(2, 3); set_holds(2, 180); set_holds(2, 44); set_holds(2, 252);
        set_count(3, 2); set_holds(3, 190); set_holds(3, 14);

        // R3 whole block installed: 101 then 100
        do_reset();
        access(101, 1'b0, 0, 0, "R3 first");
        access(100, 1'b0, 1, 0, "R3 neighbour");

        // R6 MRU eviction, R7 hit refresh
        do_reset();
        access(0,  1'b1, 0, 0, "R6");
        access(8,  1'b1, 0, 1, "R6");
        access(16, 1'b1, 0, 2, "R6");
        access(0,  1'b1, 1, 0, "R7 hit");
        access(24, 1'b1, 0, 0, "R6 evict mru");
        access(16, 1'b1, 1, 2, "R6");
        access(8,  1'b1, 1, 1, "R7 hit");
        access(0,  1'b1, 0, 1, "R6 evict mru after hit");

        // R5 LRU eviction, R7 hit refresh
        do_reset();
        access(0,  1'b0, 0, 0, "R5");
        access(8,  1'b0, 0, 1, "R5");
        access(16, 1'b0, 0, 2, "R5");
        access(0,  1'b0, 1, 0, "R7 hit");
        access(24, 1'b0, 0, 1, "R5 evict lru");
        access(16, 1'b0, 1, 2, "R7 hit");
        access(8,  1'b0, 0, 0, "R5 evict lru after hit");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule